// File: doc/BRIEF.md
# Two-Lifting Column Wavelet Core

This block performs the column pass of a (9,7) lifting wavelet transform for a line-based two-dimensional transform. Each accepted cycle carries two vertically adjacent samples of one column: an even-row sample and the odd-row sample below it. The cycle produces one lowpass and one highpass coefficient for that column. A single combinational processing element does all of the lifting arithmetic. Between visits, the four lifting state words of every column are kept in a single-port state memory that is indexed by column.

The scan that feeds the core visits each column with two consecutive pairs. On the first pair of a visit (the even phase), the core reads the column's state from memory and keeps the updated state in holding registers. On the second pair (the odd phase), it takes the state from the holding registers and writes the result back to memory. The memory therefore sees one read or one write in a cycle, never both, and about half the traffic of a core that reads and writes every cycle. A top-of-image flag makes the core ignore the stored state and start the column from a seed state built from the incoming pair.

Top module: `lift97_column_core`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid is 0, out_low and out_high are 0, and mem_re and mem_we are 0.
- R2: In the even phase (the first accepted pair after reset, and every second accepted pair after that), mem_re is 1, mem_we is 0 and mem_addr equals in_col. The lifting state is taken from the memory word at that address.
- R3: In the odd phase, mem_we is 1, mem_re is 0, and mem_addr is the column of the preceding even-phase pair. The state is taken from the holding registers, and the updated state is written to the memory.
- R4: The memory is never read and written in the same cycle. A cycle with in_valid at 0 makes no memory access and does not advance the phase.
- R5: Products are floor((c*x + 2048) / 4096), with the constants in 12-fractional-bit integers: a=-6497, b=-217, g=3616, d=1817, K=4709, Kinv=3563. The state (t,u,v,w) and the pair (e,o) give p1=t+a*e, q1=u+b*p1, p2=v+g*q1 and q2=w+d*p2, where each product is rounded.
- R6: out_valid is 1 in the cycle after each accepted pair and 0 otherwise. That cycle also carries out_low = K*q2 and out_high = Kinv*p2 for that pair.
- R7: The updated state is t'=o+a*e, u'=e+b*p1, v'=p1+g*q1 and w'=q1+d*p2. Each product is reused from R5. It is packed into mem_wdata with t' in bits [IW-1:0], u' above it, then v', and w' in the top IW bits.
- R8: When in_first is 1 in the even phase, the memory word is ignored and the seed state t=o, u=e, v=0, w=0 is used instead.
- R9: in_first has no effect in the odd phase.
- R10: Each column's state evolves only from that column's own pairs, whatever order the columns are visited in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample pair is offered this cycle |
| in_first | input | 1 | Top-of-image visit: seed the state instead of reading it |
| in_col | input | $clog2(COLS) | Column index of the pair |
| in_even | input | DW | Even-row sample, signed |
| in_odd | input | DW | Odd-row sample, signed |
| out_valid | output | 1 | Coefficients valid |
| out_low | output | IW | Lowpass coefficient, signed |
| out_high | output | IW | Highpass coefficient, signed |
| mem_addr | output | $clog2(COLS) | State memory address |
| mem_re | output | 1 | State memory read this cycle |
| mem_we | output | 1 | State memory write this cycle |
| mem_wdata | output | 4*IW | State word written to memory |

## Verification
The assertions check the access schedule in every cycle. Reads and writes are exclusive, two reads never come back to back, two writes never come back to back, and out_valid appears only after an accepted pair. The bench's scenarios are the only evidence for the arithmetic itself. They cover the coefficient values, the packing of the written state, the seed that replaces stale memory content on a top-of-image visit, the flag being ignored in the odd phase, and columns kept separate under interleaved visits. Those are compared against an independent fixed-point model.

// File: rtl/lift97_pkg.sv
package lift97_pkg;

  // Lifting constants, 12 fractional bits
  localparam int FRAC = 12;
  localparam longint C_ALPHA = -6497;
  localparam longint C_BETA  = -217;
  localparam longint C_GAMMA = 3616;
  localparam longint C_DELTA = 1817;
  localparam longint C_KSCL  = 4709;
  localparam longint C_KINV  = 3563;

  // Rounded fixed-point product: (c*x + half) >>> FRAC
  function automatic logic signed [63:0] qmul(input logic signed [63:0] c,
                                              input logic signed [63:0] x);
    logic signed [63:0] prod;
    prod = c * x + (64'sd1 <<< (FRAC - 1));
    return prod >>> FRAC;
  endfunction

endpackage

// File: rtl/lift97_pe.sv
module lift97_pe #(
  parameter int IW = 24
) (
  input  logic signed [IW-1:0] smp_e,
  input  logic signed [IW-1:0] smp_o,
  input  logic [4*IW-1:0]      st_cur,
  output logic [4*IW-1:0]      st_nxt,
  output logic signed [IW-1:0] coef_lo,
  output logic signed [IW-1:0] coef_hi
);
  import lift97_pkg::*;

  logic signed [IW-1:0] t_q, u_q, v_q, w_q;
  logic signed [IW-1:0] ae, p1, bp, q1, gq, p2, dp, q2;

  always_comb begin
    t_q = signed'(st_cur[0*IW +: IW]);
    u_q = signed'(st_cur[1*IW +: IW]);
    v_q = signed'(st_cur[2*IW +: IW]);
    w_q = signed'(st_cur[3*IW +: IW]);
    // each product feeds both an output path and a next-state word
    ae  = IW'(qmul(C_ALPHA, 64'(smp_e)));
    p1  = t_q + ae;
    bp  = IW'(qmul(C_BETA, 64'(p1)));
    q1  = u_q + bp;
    gq  = IW'(qmul(C_GAMMA, 64'(q1)));
    p2  = v_q + gq;
    dp  = IW'(qmul(C_DELTA, 64'(p2)));
    q2  = w_q + dp;
    st_nxt  = {q1 + dp, p1 + gq, smp_e + bp, smp_o + ae};
    coef_lo = IW'(qmul(C_KSCL, 64'(q2)));
    coef_hi = IW'(qmul(C_KINV, 64'(p2)));
  end

endmodule

// File: rtl/lift97_state_mem.sv
module lift97_state_mem #(
  parameter int DEPTH = 16,
  parameter int WW    = 96,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [WW-1:0] wdata,
  output logic [WW-1:0] rdata
);
  logic [WW-1:0] store [DEPTH];

  // single port: one address serves both the read and the write
  always_ff @(posedge clk) begin
    if (wr_en) store[addr] <= wdata;
  end

  assign rdata = store[addr];

endmodule

// File: rtl/lift97_column_core.sv
module lift97_column_core #(
  parameter int COLS = 16,
  parameter int DW   = 12,
  parameter int IW   = 24,
  localparam int AW  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int SW  = 4 * IW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_first,
  input  logic [AW-1:0]        in_col,
  input  logic signed [DW-1:0] in_even,
  input  logic signed [DW-1:0] in_odd,
  output logic                 out_valid,
  output logic signed [IW-1:0] out_low,
  output logic signed [IW-1:0] out_high,
  output logic [AW-1:0]        mem_addr,
  output logic                 mem_re,
  output logic                 mem_we,
  output logic [SW-1:0]        mem_wdata
);

  logic                 odd_phase;
  logic [SW-1:0]        hold_state;
  logic [AW-1:0]        hold_col;
  logic [SW-1:0]        mem_rdata, seed_state, pe_state, pe_next;
  logic signed [IW-1:0] ext_e, ext_o, pe_lo, pe_hi;

  // named schedule events
  logic rd_evt, wr_evt;
  assign rd_evt = in_valid && !odd_phase;
  assign wr_evt = in_valid && odd_phase;

  assign ext_e      = IW'(in_even);
  assign ext_o      = IW'(in_odd);
  assign seed_state = {{(2*IW){1'b0}}, ext_e, ext_o};

  assign mem_addr  = odd_phase ? hold_col : in_col;
  assign mem_re    = rd_evt;
  assign mem_we    = wr_evt;
  assign mem_wdata = pe_next;

  always_comb begin
    if (odd_phase)     pe_state = hold_state;
    else if (in_first) pe_state = seed_state;
    else               pe_state = mem_rdata;
  end

  lift97_state_mem #(.DEPTH(COLS), .WW(SW)) u_mem (
    .clk   (clk),
    .wr_en (wr_evt),
    .addr  (mem_addr),
    .wdata (pe_next),
    .rdata (mem_rdata)
  );

  lift97_pe #(.IW(IW)) u_pe (
    .smp_e   (ext_e),
    .smp_o   (ext_o),
    .st_cur  (pe_state),
    .st_nxt  (pe_next),
    .coef_lo (pe_lo),
    .coef_hi (pe_hi)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      odd_phase  <= 1'b0;
      hold_state <= '0;
      hold_col   <= '0;
      out_valid  <= 1'b0;
      out_low    <= '0;
      out_high   <= '0;
    end else begin
      odd_phase <= odd_phase ^ in_valid;
      if (rd_evt) begin
        hold_state <= pe_next;
        hold_col   <= in_col;
      end
      out_valid <= in_valid;
      if (in_valid) begin
        out_low  <= pe_lo;
        out_high <= pe_hi;
      end
    end
  end

  // R4
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  // R2
  rd_not_twice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> !rd_evt);

  // R3
  wr_not_twice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);

  // R6
  out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(odd_phase));

endmodule

// File: tb/lift97_column_core_test.sv
`timescale 1ns/1ps
module lift97_column_core_test;
  localparam int COLS = 4;
  localparam int DW   = 12;
  localparam int IW   = 24;
  localparam int AW   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0;
  logic [AW-1:0] in_col = '0;
  logic signed [DW-1:0] in_even = '0, in_odd = '0;
  logic out_valid, mem_re, mem_we;
  logic signed [IW-1:0] out_low, out_high;
  logic [AW-1:0] mem_addr;
  logic [4*IW-1:0] mem_wdata;

  always #2.5 clk = ~clk;

  lift97_column_core #(.COLS(COLS), .DW(DW), .IW(IW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_col(in_col), .in_even(in_even), .in_odd(in_odd),
    .out_valid(out_valid), .out_low(out_low), .out_high(out_high),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  int errs = 0, checks = 0;
  longint mt[COLS], mu[COLS], mv[COLS], mw[COLS];
  bit pv = 0, ph = 0;
  longint plo = 0, phi = 0;
  string ptag = "";

  function automatic longint rq(longint c, longint x);
    real r;
    r = (real'(c * x) + 2048.0) / 4096.0;
    return longint'($floor(r));
  endfunction

  function automatic longint wslice(int k);
    logic signed [IW-1:0] s;
    s = signed'(mem_wdata[k*IW +: IW]);
    return longint'(s);
  endfunction

  function automatic longint smp(int p, int c, int r);
    case (p)
      0: return longint'(c * 37 + r * 11 - 300);
      1: return (r % 2 == 1) ? 64'sd2047 : longint'(c - 2048);
      default: return ((longint'(c * 131 + r * 71 + 7) * 40503) % 4096) - 2048;
    endcase
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, bit fst, int col, longint e, longint o, string otag);
    longint t, u, vv, w, ae, p1, bp, q1, gq, p2, dp, q2;
    longint nt, nu, nv, nw;
    @(negedge clk);
    chk("R6 out_valid", longint'(out_valid), longint'(pv));
    if (pv) begin
      chk({ptag, " low"}, longint'(out_low), plo);
      chk({ptag, " high"}, longint'(out_high), phi);
    end
    in_valid = v; in_first = fst; in_col = col[AW-1:0];
    in_even = e[DW-1:0]; in_odd = o[DW-1:0];
    #1;
    if (!v) begin
      chk("R4 idle mem_re", longint'(mem_re), 0);
      chk("R4 idle mem_we", longint'(mem_we), 0);
      pv = 0;
    end else begin
      if (!ph && fst) begin t = o; u = e; vv = 0; w = 0; end
      else begin t = mt[col]; u = mu[col]; vv = mv[col]; w = mw[col]; end
      ae = rq(-6497, e); p1 = t + ae;
      bp = rq(-217, p1); q1 = u + bp;
      gq = rq(3616, q1); p2 = vv + gq;
      dp = rq(1817, p2); q2 = w + dp;
      nt = o + ae; nu = e + bp; nv = p1 + gq; nw = q1 + dp;
      mt[col] = nt; mu[col] = nu; mv[col] = nv; mw[col] = nw;
      if (!ph) begin
        chk("R2 mem_re", longint'(mem_re), 1);
        chk("R2 mem_we", longint'(mem_we), 0);
        chk("R2 mem_addr", longint'(mem_addr), longint'(col));
      end else begin
        chk("R3 mem_we", longint'(mem_we), 1);
        chk("R3 mem_re", longint'(mem_re), 0);
        chk("R3 mem_addr", longint'(mem_addr), longint'(col));
        chk("R7 word t", wslice(0), nt);
        chk("R7 word u", wslice(1), nu);
        chk("R7 word v", wslice(2), nv);
        chk("R7 word w", wslice(3), nw);
      end
      pv = 1; plo = rq(4709, q2); phi = rq(3563, p2); ptag = otag;
      ph = ~ph;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errs++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 state during reset
    chk("R1 out_valid", longint'(out_valid), 0);
    chk("R1 out_low", longint'(out_low), 0);
    chk("R1 out_high", longint'(out_high), 0);
    chk("R1 mem_re", longint'(mem_re), 0);
    chk("R1 mem_we", longint'(mem_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after release", longint'(out_valid), 0);
    for (int p = 0; p < 3; p++) begin
      for (int vg = 0; vg < 4; vg++) begin
        for (int c = 0; c < COLS; c++) begin
          step(1'b1, vg == 0, c, smp(p, c, 4*vg), smp(p, c, 4*vg+1),
               (vg == 0) ? "R8 seed" : ((c > 0) ? "R10 column" : "R5 lift"));
          if (c == 1) step(1'b0, 1'b0, 0, 0, 0, "");
          step(1'b1, p == 1, c, smp(p, c, 4*vg+2), smp(p, c, 4*vg+3),
               (p == 1) ? "R9 odd flag" : "R5 lift");
        end
      end
    end
    step(1'b0, 1'b0, 0, 0, 0, "");
    step(1'b0, 1'b0, 0, 0, 0, "");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule